// File: doc/BRIEF.md
# Synchronised Edge-Capture Timer

This block keeps a free-running 32-bit timestamp counter and latches its value into a capture register when a chosen edge appears on a monitored input. A sync pulse reloads the counter with a programmable phase value. Several such units can share one sync pulse taken from a PWM reference. Their timestamps then share a time origin, and the difference between the capture values of two units is the phase delay between the waveforms they watch.

The monitored input is asynchronous. It passes through a two-flop synchroniser before edge detection. A capture sets a sticky valid flag, which drives the interrupt output. A capture that arrives while the flag is still set replaces the stored timestamp and sets an overrun bit. Software reaches the control, phase, status and capture registers through a simple word-wide read/write port.

Top module: `sync_capture_timer`

## Requirements
- R1: After reset, the four registers read as zero and `irq_o` is low.
- R2: When `sync_i` is high at a clock edge, the counter takes the value of the phase register (address 1) at that edge. The phase register is read/write, and its default of zero aligns the unit with the reference sync.
- R3: In any cycle without sync, the counter increases by one and wraps from 2^32-1 to 0.
- R4: Bit 0 of the control register (address 0) selects the capture edge: 0 selects rising and 1 selects falling. An edge of the other polarity captures nothing and leaves the status unchanged.
- R5: The capture register (address 3, read-only) takes the counter value of the cycle in which the synchronised edge is seen. With sync at edge E0 and the input changed just after edge E0+d, the captured value is phase+d+2.
- R6: A capture sets status bit 0 (valid), and `irq_o` is high whenever valid is set.
- R7: Status bits are cleared by writing 1 to them at address 2. Writing 0 has no effect.
- R8: A capture while valid is set overwrites the capture register and sets status bit 1 (overrun).
- R9: When a sync and a capture fall at the same clock edge, the capture register receives the counter value from before the sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected address (combinational) |
| sig_i | input | 1 | Monitored asynchronous input |
| sync_i | input | 1 | Sync pulse that reloads the counter with the phase value |
| irq_o | output | 1 | Interrupt, high while a capture is pending |

## Verification
A change on the input made just after edge E0+d is first sampled at edge E0+d+1. It is then seen as an edge and captured at E0+d+3, and the captured value is phase+d+2. The bench therefore waits five cycles after each stimulus before it reads the capture and status registers. Inputs are driven on falling clock edges, and the combinational read data is sampled 1 ns after the address is set. The same-cycle test puts the sync pulse exactly on edge E0+d+3, so the captured value shows whether the value from before the sync was kept.

// File: rtl/sct_pkg.sv
package sct_pkg;
  typedef logic [1:0] reg_addr_t;
  localparam reg_addr_t ADDR_CTRL  = 2'd0;
  localparam reg_addr_t ADDR_PHASE = 2'd1;
  localparam reg_addr_t ADDR_STAT  = 2'd2;
  localparam reg_addr_t ADDR_CAPT  = 2'd3;
  localparam int STAT_VALID_BIT = 0;
  localparam int STAT_OVR_BIT   = 1;
endpackage

// File: rtl/sct_edge_det.sv
module sct_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= sig_i;
        else sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= sync_q[SYNC_STAGES-1];
  end

  logic cur;
  assign cur    = sync_q[SYNC_STAGES-1];
  assign edge_o = fall_sel_i ? (prev_q & ~cur) : (cur & ~prev_q);
endmodule

// File: rtl/sct_counter.sv
module sct_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] phase_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (sync_i) cnt_o <= phase_i;
    else cnt_o <= cnt_o + 1'b1;
  end

  // R2
  sync_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> cnt_o == $past(phase_i));
  // R3
  free_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/sct_regs.sv
module sct_regs
  import sct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  reg_addr_t        reg_addr_i,
  input  logic             reg_we_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             fall_sel_o,
  output logic [CNT_W-1:0] phase_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cap_q;
  logic             valid_q, ovr_q;
  logic             wr_ctrl, wr_phase, wr_stat;

  assign wr_ctrl  = reg_we_i && reg_addr_i == ADDR_CTRL;
  assign wr_phase = reg_we_i && reg_addr_i == ADDR_PHASE;
  assign wr_stat  = reg_we_i && reg_addr_i == ADDR_STAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_sel_o <= 1'b0;
      phase_o    <= '0;
    end else begin
      if (wr_ctrl)  fall_sel_o <= reg_wdata_i[0];
      if (wr_phase) phase_o    <= reg_wdata_i;
    end
  end

  // capture wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (capture_i) cap_q <= cnt_i;
      if (capture_i) valid_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[STAT_VALID_BIT]) valid_q <= 1'b0;
      if (capture_i && valid_q) ovr_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[STAT_OVR_BIT]) ovr_q <= 1'b0;
    end
  end

  assign irq_o = valid_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL:  reg_rdata_o[0] = fall_sel_o;
      ADDR_PHASE: reg_rdata_o = phase_o;
      ADDR_STAT: begin
        reg_rdata_o[STAT_VALID_BIT] = valid_q;
        reg_rdata_o[STAT_OVR_BIT]   = ovr_q;
      end
      ADDR_CAPT:  reg_rdata_o = cap_q;
    endcase
  end

  // R5 R9
  cap_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> cap_q == $past(cnt_i));
  // R6
  cap_sets_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> irq_o);
  // R7
  w1c_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && reg_wdata_i[STAT_VALID_BIT] && !capture_i) |=> !valid_q);
  // R8
  overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && valid_q) |=> ovr_q);
endmodule

// File: rtl/sync_capture_timer.sv
module sync_capture_timer
  import sct_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       reg_addr_i,
  input  logic             reg_we_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  input  logic             sig_i,
  input  logic             sync_i,
  output logic             irq_o
);
  logic             fall_sel, capture;
  logic [CNT_W-1:0] phase, cnt;

  sct_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .sig_i, .fall_sel_i(fall_sel), .edge_o(capture)
  );

  sct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .sync_i, .phase_i(phase), .cnt_o(cnt)
  );

  sct_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .reg_addr_i(reg_addr_t'(reg_addr_i)), .reg_we_i, .reg_wdata_i, .reg_rdata_o,
    .capture_i(capture), .cnt_i(cnt),
    .fall_sel_o(fall_sel), .phase_o(phase), .irq_o
  );
endmodule

// File: tb/sync_capture_timer_test.sv
module sync_capture_timer_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 0, rst_n = 0;
  logic [1:0]  addr = 0;
  logic        we = 0;
  logic [31:0] wdata = 0, rdata;
  logic        sig = 0, sync = 0, irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_capture_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sig_i(sig), .sync_i(sync), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  // sync at E0, input flipped just after E0+d: capture = phase+d+2
  task automatic cap_vec(bit fall, logic [31:0] ph, int d);
    logic [31:0] v;
    wr(0, {31'd0, fall});
    sig = fall;
    repeat (5) @(negedge clk);
    wr(2, 3);
    wr(1, ph);
    @(negedge clk); sync = 1;
    @(negedge clk); sync = 0;
    repeat (d) @(negedge clk);
    sig = ~fall;
    repeat (5) @(negedge clk);
    rd(3, v); check("R2 R3 R4 R5 capture", v, ph + d + 2);
    rd(2, v); check("R6 status", v, 32'd1);
    check("R6 irq", {31'd0, irq}, 32'd1);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] phs [3] = '{32'd0, 32'd300, 32'hFFFF_FFFE};
    int          dly [7] = '{0, 1, 2, 3, 4, 5, 20};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); check("R1 reset reg", v, 32'd0);
    end
    check("R1 reset irq", {31'd0, irq}, 32'd0);

    // R10-like phase readback (R2)
    wr(1, 32'hA5A5_0001); rd(1, v); check("R2 phase rw", v, 32'hA5A5_0001);

    // sweep: edge select x phase x delay
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 3; p++)
        for (int k = 0; k < 7; k++)
          cap_vec(e[0], phs[p], dly[k]);

    // R4 opposite edge ignored (rise mode, falling input)
    cap_vec(1'b0, 32'd1000, 3);
    wr(2, 3);
    sig = 0;
    repeat (6) @(negedge clk);
    rd(2, v); check("R4 opposite edge status", v, 32'd0);
    rd(3, v); check("R4 opposite edge capture", v, 32'd1005);
    check("R4 opposite edge irq", {31'd0, irq}, 32'd0);

    // R8 overrun: captures at phase+2 and phase+8
    wr(2, 3);
    wr(1, 32'd50);
    @(negedge clk); sync = 1;
    @(negedge clk); sync = 0; sig = 1;
    repeat (3) @(negedge clk); sig = 0;
    repeat (3) @(negedge clk); sig = 1;
    repeat (6) @(negedge clk);
    rd(3, v); check("R8 overwrite", v, 32'd58);
    rd(2, v); check("R8 overrun", v, 32'd3);

    // R7 write-one-to-clear
    wr(2, 0); rd(2, v); check("R7 write zero", v, 32'd3);
    wr(2, 1); rd(2, v); check("R7 clear valid", v, 32'd2);
    check("R7 irq low", {31'd0, irq}, 32'd0);
    wr(2, 2); rd(2, v); check("R7 clear overrun", v, 32'd0);

    // R9 sync and capture at same edge E0+7 (d=4)
    sig = 0;
    repeat (5) @(negedge clk);
    wr(2, 3);
    wr(1, 32'd100);
    @(negedge clk); sync = 1;
    @(negedge clk); sync = 0;
    repeat (4) @(negedge clk); sig = 1;
    repeat (2) @(negedge clk); sync = 1;
    @(negedge clk); sync = 0;
    repeat (4) @(negedge clk);
    rd(3, v); check("R9 pre-sync capture", v, 32'd106);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule